// File: doc/BRIEF.md
# PCI Slot Hotplug Register Controller

This block keeps the hotplug state of up to 32 PCI slots and exposes it to firmware through four 32-bit registers. Each register holds one bit per slot. Platform logic reports per-slot events: a device was hot-added, a device was cold-plugged at boot, or removal was requested. Firmware reads which slots need a device check and which are waiting for removal. It completes a removal by writing the slot to the eject register. That write sends a one-cycle eject strobe to the slot-power logic. Any hot event raises a single event-status bit toward the general-purpose event logic, which clears it with an acknowledge pulse.

Firmware reaches the registers through a request channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The block lowers `req_ready` only while a platform reset is being processed, so requesters must hold the request until it is taken. A read answers one cycle after acceptance with `rsp_valid`. The response channel has no back-pressure, so the requester must be able to take the response in that cycle.

When the platform reset request arrives, every removal that is still waiting is carried out first, one slot per cycle, starting with the lowest slot. After that, the hotplug-capable mask and the present mask are rebuilt from the slot inputs.

Top module: `slot_hotplug_regs`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. An accepted read gives `rsp_valid` high with `rsp_rdata` in the next cycle. An accepted write never produces `rsp_valid`.
- R2: A read at offset 0x0 (insertion) returns the present mask ANDed with the hotplug-capable mask. No separate insertion state is kept.
- R3: A read at offset 0x4 returns the latched removal-pending mask. Writes to offsets 0x0, 0x4 and 0xC change no state.
- R4: A write at offset 0x8 (eject) acts only on the lowest-numbered set bit of the written value and clears that slot's removal-pending bit. A written value of zero has no effect.
- R5: When the ejected slot has `slot_fixed` low, its present bit is cleared and `eject_pulse` is high for exactly one cycle on that bit alone, in the cycle after acceptance. When `slot_fixed` is high, the present bit stays set and no pulse is given.
- R6: A read at offset 0x8 returns the features word, which is all zeros.
- R7: A read at offset 0xC returns the hotplug-capable mask. After a reset this mask equals the inverse of `slot_fixed`.
- R8: `hot_add` sets present bits and `hot_remove` sets removal-pending bits. Either one sets `evt_pending` in the next cycle. `evt_ack` clears `evt_pending`, except that a new event in the same cycle wins.
- R9: `cold_plug` sets present bits and does not raise `evt_pending`.
- R10: A `plat_reset` pulse drops `req_ready` and ejects every pending removal, one per cycle and lowest slot first, following the R5 rules. It then loads the present mask from `slot_occupied` and the capable mask from `~slot_fixed`, and raises `req_ready` again.
- R11: A request whose `req_be` is not all ones, or whose `req_addr[1:0]` is nonzero, changes no state. If it is a read, it returns zero.
- R12: When a present or removal bit is set by an input in the same cycle an eject clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| plat_reset | input | 1 | Platform reset request: drain removals, then rebuild the masks |
| slot_occupied | input | 32 | Slots currently populated, loaded into the present mask on rebuild |
| slot_fixed | input | 32 | Slots holding a device that cannot be hot-plugged |
| hot_add | input | 32 | Hot-add strobes, one per slot |
| hot_remove | input | 32 | Removal request strobes, one per slot |
| cold_plug | input | 32 | Boot-time presence strobes, one per slot |
| evt_ack | input | 1 | Clears the event-status bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset within the register window |
| req_be | input | 4 | Byte enables; all ones marks a full access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| eject_pulse | output | 32 | One-cycle strobe on the slot being powered off |
| evt_pending | output | 1 | Hotplug event status bit |

## Verification
The hardest state to reach from the ports is a platform reset with several removals pending, some of them on fixed slots. The drain order, the skipped strobes and the rebuilt masks only show up together in that case. The stimulus builds it with random `hot_remove` masks over a random `slot_fixed` pattern, fires `plat_reset`, records every `eject_pulse` cycle by cycle, and then checks the order and the mask contents. A directed case applies an eject in the same cycle as a hot-add to the same slot, to expose the set-over-clear priority.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_DRAIN   = 2'd1,
    SEQ_REBUILD = 2'd2
  } seq_e;

  // Register index taken from req_addr[3:2]; software decodes these offsets
  typedef enum logic [1:0] {
    RIX_INSERT = 2'd0,
    RIX_REMOVE = 2'd1,
    RIX_EJECT  = 2'd2,
    RIX_CAPMSK = 2'd3
  } reg_ix_e;
endpackage

// File: rtl/hp_lowest_bit.sv
module hp_lowest_bit #(
  parameter int N = 32
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] onehot,
  output logic         any
);
  logic [N:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign below[i+1] = below[i] | vec[i];
    assign onehot[i]  = vec[i] & ~below[i];
  end
  assign any = below[N];
endmodule

// File: rtl/hp_seq_ctl.sv
module hp_seq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic plat_reset,
  input  logic pend_any,
  output logic idle,
  output logic drain_fire,
  output logic rebuild_fire
);
  import hp_pkg::*;

  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE:    if (plat_reset) st_d = SEQ_DRAIN;
      SEQ_DRAIN:   if (!pend_any) st_d = SEQ_REBUILD;
      SEQ_REBUILD: st_d = SEQ_IDLE;
      default:     st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_DRAIN;
    else        st_q <= st_d;
  end

  assign idle         = (st_q == SEQ_IDLE);
  assign drain_fire   = (st_q == SEQ_DRAIN) && pend_any;
  assign rebuild_fire = (st_q == SEQ_REBUILD);
endmodule

// File: rtl/hp_read_mux.sv
module hp_read_mux #(
  parameter int N = 32
) (
  input  logic [1:0]   ix,
  input  logic         full,
  input  logic [N-1:0] present,
  input  logic [N-1:0] capable,
  input  logic [N-1:0] removal,
  output logic [N-1:0] rdata
);
  import hp_pkg::*;

  always_comb begin
    rdata = '0;
    if (full) begin
      unique case (reg_ix_e'(ix))
        RIX_INSERT: rdata = present & capable;
        RIX_REMOVE: rdata = removal;
        RIX_EJECT:  rdata = '0;
        RIX_CAPMSK: rdata = capable;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/slot_hotplug_regs.sv
module slot_hotplug_regs #(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   plat_reset,
  input  logic [NUM_SLOTS-1:0]   slot_occupied,
  input  logic [NUM_SLOTS-1:0]   slot_fixed,
  input  logic [NUM_SLOTS-1:0]   hot_add,
  input  logic [NUM_SLOTS-1:0]   hot_remove,
  input  logic [NUM_SLOTS-1:0]   cold_plug,
  input  logic                   evt_ack,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [NUM_SLOTS/8-1:0] req_be,
  input  logic [NUM_SLOTS-1:0]   req_wdata,
  output logic                   rsp_valid,
  output logic [NUM_SLOTS-1:0]   rsp_rdata,
  output logic [NUM_SLOTS-1:0]   eject_pulse,
  output logic                   evt_pending
);
  import hp_pkg::*;

  localparam int BE_W = NUM_SLOTS / 8;

  logic [NUM_SLOTS-1:0] present_q, cap_q, removal_q;
  logic [NUM_SLOTS-1:0] pick_src, pick_oh, clr_sel, off_mask, rd_word;
  logic                 pick_any, idle, drain_fire, rebuild_fire;
  logic                 accept, full, ej_wr, do_eject;
  logic [1:0]           ix;

  assign accept = req_valid && req_ready;
  assign full   = (req_be == {BE_W{1'b1}}) && (req_addr[1:0] == 2'b00);
  assign ix     = req_addr[3:2];
  assign ej_wr  = accept && req_write && full && (reg_ix_e'(ix) == RIX_EJECT);

  hp_seq_ctl u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .plat_reset   (plat_reset),
    .pend_any     (|removal_q),
    .idle         (idle),
    .drain_fire   (drain_fire),
    .rebuild_fire (rebuild_fire)
  );

  assign req_ready = idle;

  // Draining and firmware ejects share one lowest-bit picker
  assign pick_src = drain_fire ? removal_q : req_wdata;

  hp_lowest_bit #(.N(NUM_SLOTS)) u_pick (
    .vec    (pick_src),
    .onehot (pick_oh),
    .any    (pick_any)
  );

  assign do_eject = (drain_fire || ej_wr) && pick_any;
  assign clr_sel  = do_eject ? pick_oh : '0;
  assign off_mask = clr_sel & ~slot_fixed;

  hp_read_mux #(.N(NUM_SLOTS)) u_rd (
    .ix      (ix),
    .full    (full),
    .present (present_q),
    .capable (cap_q),
    .removal (removal_q),
    .rdata   (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q   <= '0;
      cap_q       <= '1;
      removal_q   <= '0;
      evt_pending <= 1'b0;
      eject_pulse <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      removal_q   <= (removal_q & ~clr_sel) | hot_remove;
      if (rebuild_fire) begin
        present_q <= slot_occupied;
        cap_q     <= ~slot_fixed;
      end else begin
        present_q <= (present_q & ~off_mask) | hot_add | cold_plug;
      end
      evt_pending <= (evt_pending && !evt_ack) || (|hot_add) || (|hot_remove);
      eject_pulse <= off_mask;
      rsp_valid   <= accept && !req_write;
      rsp_rdata   <= (accept && !req_write) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic [3:0]   req_addr,
  input logic [N/8-1:0] req_be,
  input logic [N-1:0] hot_add,
  input logic [N-1:0] hot_remove,
  input logic         evt_pending,
  input logic [N-1:0] eject_pulse,
  input logic         rsp_valid,
  input logic [N-1:0] rsp_rdata,
  input logic [N-1:0] present_q,
  input logic [N-1:0] cap_q,
  input logic [N-1:0] removal_q
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R1

  AST_INSERT_SYNTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr) == 4'h0 && $past(req_be) == '1)
      |-> rsp_rdata == $past(present_q & cap_q)); // R2

  AST_EJECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eject_pulse)); // R4

  AST_EJECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|eject_pulse) |-> ((present_q & eject_pulse & ~$past(hot_add)) == '0
                        && (removal_q & eject_pulse & ~$past(hot_remove)) == '0)); // R5

  AST_FEATURES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr[3:2]) == 2'd2) |-> rsp_rdata == '0); // R6

  AST_EVT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hot_add) || (|hot_remove)) |=> evt_pending); // R8

  AST_EVT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_pending && !(|hot_add) && !(|hot_remove)) |=> !evt_pending); // R9

  AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (removal_q & ~$past(hot_remove)) == '0); // R10
endmodule

bind slot_hotplug_regs hp_checker #(.N(NUM_SLOTS)) u_hp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_be      (req_be),
  .hot_add     (hot_add),
  .hot_remove  (hot_remove),
  .evt_pending (evt_pending),
  .eject_pulse (eject_pulse),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .present_q   (present_q),
  .cap_q       (cap_q),
  .removal_q   (removal_q)
);

// File: tb/slot_hotplug_regs_bench.sv
`timescale 1ns/1ps
module slot_hotplug_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        plat_reset = 1'b0;
  logic [31:0] slot_occupied = '0, slot_fixed = '0;
  logic [31:0] hot_add = '0, hot_remove = '0, cold_plug = '0;
  logic        evt_ack = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0, req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, evt_pending;
  logic [31:0] rsp_rdata, eject_pulse;

  int n_checks = 0, n_fail = 0;
  logic [31:0] m_present = '0, m_cap = '1, m_removal = '0;
  logic        m_evt = 1'b0;

  always #2.5 clk = ~clk;

  slot_hotplug_regs u_slot_hotplug_regs (.*);

  function automatic logic [31:0] low_bit(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [3:0] be);
    if (be != 4'hF || a[1:0] != 2'b00) return '0;
    case (a[3:2])
      2'd0: return m_present & m_cap;
      2'd1: return m_removal;
      2'd2: return '0;
      default: return m_cap;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic [31:0] add_same, input string req);
    logic [31:0] exp_rd, exp_pulse, sel;
    logic full;
    full   = (be == 4'hF) && (a[1:0] == 2'b00);
    exp_rd = exp_read(a, be);
    sel    = (wr && full && a[3:2] == 2'd2) ? low_bit(d) : '0;
    exp_pulse = sel & ~slot_fixed;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    hot_add = add_same;
    @(negedge clk);
    req_valid = 1'b0; hot_add = '0;
    if (wr) begin
      check({req, " no rsp on write"}, {31'd0, rsp_valid}, 32'd0);
      check({req, " eject pulse"}, eject_pulse, exp_pulse);
      m_removal = m_removal & ~sel;
      m_present = (m_present & ~exp_pulse) | add_same;
      if (|add_same) m_evt = 1'b1;
    end else begin
      check({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
      check({req, " rdata"}, rsp_rdata, exp_rd);
    end
  endtask

  task automatic events(input logic [31:0] add, input logic [31:0] rem,
                        input logic [31:0] cold, input logic ack, input string req);
    @(negedge clk);
    hot_add = add; hot_remove = rem; cold_plug = cold; evt_ack = ack;
    @(negedge clk);
    hot_add = '0; hot_remove = '0; cold_plug = '0; evt_ack = 1'b0;
    m_present = m_present | add | cold;
    m_removal = m_removal | rem;
    m_evt = (m_evt && !ack) || (|add) || (|rem);
    check({req, " evt_pending"}, {31'd0, evt_pending}, {31'd0, m_evt});
  endtask

  task automatic do_plat_reset();
    logic [31:0] seen, exp_seen;
    int last;
    seen = '0; last = -1;
    exp_seen = m_removal & ~slot_fixed;
    @(negedge clk); plat_reset = 1'b1;
    @(negedge clk); plat_reset = 1'b0;
    check("R10 ready low while draining", {31'd0, req_ready}, 32'd0);
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (|eject_pulse) begin
        int idx = $clog2(eject_pulse);
        if (!$onehot(eject_pulse) || idx <= last) begin
          n_fail++;
          $display("FAIL R10 drain order: actual %h expected onehot above slot %0d", eject_pulse, last);
        end
        last = idx;
        seen |= eject_pulse;
      end
      if (req_ready) break;
    end
    check("R10 ready restored", {31'd0, req_ready}, 32'd1);
    check("R10 drained strobes (R5 fixed skipped)", seen, exp_seen);
    m_removal = '0; m_present = slot_occupied; m_cap = ~slot_fixed;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    slot_occupied = 32'h0000_00F3;
    slot_fixed    = 32'h0000_0081;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 10 && !req_ready; c++) @(negedge clk);
    m_present = slot_occupied; m_cap = ~slot_fixed;
    check("R10 reset ready", {31'd0, req_ready}, 32'd1);
    check("R8 reset evt low", {31'd0, evt_pending}, 32'd0);
    access(0, 4'h0, 4'hF, 0, 0, "R2 insert after reset");
    access(0, 4'hC, 4'hF, 0, 0, "R7 capable after reset");
    access(0, 4'h4, 4'hF, 0, 0, "R3 removal after reset");
    access(0, 4'h8, 4'hF, 0, 0, "R6 features");

    events(0, 0, 32'h0000_0100, 0, "R9 cold plug quiet");
    access(0, 4'h0, 4'hF, 0, 0, "R9 cold plug present");
    events(32'h0000_1000, 0, 0, 0, "R8 hot add raises");
    events(0, 32'h0000_1001, 0, 0, "R8 hot remove raises");
    events(0, 0, 0, 1, "R8 ack clears");
    access(0, 4'h4, 4'hF, 0, 0, "R3 removal latched");
    access(1, 4'h4, 4'hF, 32'hFFFF_FFFF, 0, "R3 write removal ignored");
    access(1, 4'h0, 4'hF, 32'h0, 0, "R3 write insert ignored");
    access(1, 4'hC, 4'hF, 32'h0, 0, "R3 write capable ignored");
    access(0, 4'h4, 4'hF, 0, 0, "R3 removal unchanged");
    access(0, 4'hC, 4'hF, 0, 0, "R3 capable unchanged");
    access(1, 4'h8, 4'hF, 32'h0, 0, "R4 eject zero no effect");
    access(0, 4'h4, 4'hF, 0, 0, "R4 removal after zero eject");
    access(1, 4'h8, 4'hF, 32'h0000_1001, 0, "R5 eject fixed slot 0");
    access(0, 4'h0, 4'hF, 0, 0, "R5 fixed slot stays present");
    access(1, 4'h8, 4'h7, 32'h0000_1000, 0, "R11 partial eject dropped");
    access(0, 4'h6, 4'hF, 0, 0, "R11 misaligned read zero");
    access(0, 4'h4, 4'h3, 0, 0, "R11 partial read zero");
    access(0, 4'h4, 4'hF, 0, 0, "R11 removal intact");
    access(1, 4'h8, 4'hF, 32'hF000_1000, 0, "R4 lowest bit of several");
    access(0, 4'h0, 4'hF, 0, 0, "R4 only lowest slot cleared");
    access(1, 4'h8, 4'hF, 32'h0000_0010, 32'h0000_0010, "R12 add beats eject");
    access(0, 4'h0, 4'hF, 0, 0, "R12 present kept");

    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 6;
      logic [31:0] r = $urandom;
      logic [3:0]  a = 4'(($urandom % 4) * 4);
      case (op)
        0: events(32'd1 << ($urandom % 32), 0, 0, 0, "R8 random add");
        1: events(0, r & $urandom & $urandom, 0, 0, "R8 random remove");
        2: access(0, a, 4'hF, 0, 0, "R2 R3 R7 random read");
        3: access(1, 4'h8, 4'hF, ($urandom % 3 == 0) ? m_removal : (r & $urandom), 0, "R4 R5 random eject");
        4: events(0, 0, 0, 1, "R8 random ack");
        default: access($urandom % 2, 4'(a | 4'($urandom % 4)), 4'($urandom % 15), r, 0, "R11 random bad access");
      endcase
      if (it % 100 == 99) begin
        events(0, $urandom | slot_fixed, 0, 0, "R10 preload removals");
        slot_fixed    = $urandom & $urandom;
        slot_occupied = $urandom;
        do_plat_reset();
        access(0, 4'h0, 4'hF, 0, 0, "R10 present rebuilt");
        access(0, 4'hC, 4'hF, 0, 0, "R7 capable rebuilt");
        access(0, 4'h4, 4'hF, 0, 0, "R10 removals drained");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule